// File: doc/BRIEF.md
# Cache Access Outcome Classifier

This block watches the access stream of a small direct-mapped cache and sorts every access into one of four kinds. A hit is a temporal hit when the word was already touched during the current residency of its line. It is a spatial hit when only a fill triggered by a neighbouring word brought the word in. A miss is compulsory when the block has never been filled into the cache. It is a conflict miss when the block was resident at some earlier time and has since been displaced.

The monitor keeps its own state. Each cache line has a touched bit for every word. Each memory block of the parameterised word address space has a loaded-once bit. The cache reports its hit or miss result alongside each access, and it reports every line fill as a separate event that carries the word address that caused the fill. The block does not decide hits and does not choose what to replace. For each access it gives a registered label with a strobe, and it keeps one saturating counter for each kind. A select input reads any counter out, and a clear input empties the counters.

Top module: `cache_outcome_classifier`

## Requirements
- R1: An access with `acc_hit`=1 to a word whose touched bit is set is labelled code 0 (temporal hit).
- R2: An access with `acc_hit`=1 to a word whose touched bit is clear is labelled code 1 (spatial hit).
- R3: An access with `acc_hit`=0 to a block whose loaded-once bit is clear is labelled code 2 (compulsory miss).
- R4: An access with `acc_hit`=0 to a block whose loaded-once bit is set is labelled code 3 (conflict miss).
- R5: A fill at word address A does three things. It clears every touched bit of line A[OFF_W+IDX_W-1:OFF_W]. It sets the touched bit of word A[OFF_W-1:0]. It sets the loaded-once bit of block A[ADDR_W-1:OFF_W]. A hit access sets the touched bit of its word, and this update is applied after a fill in the same cycle. Every access is classified with the state that held before that cycle's updates.
- R6: `lbl_valid` is high in exactly the cycle after an access is presented, with `lbl_code` holding that access's label. At all other times `lbl_valid` is low.
- R7: Each label increments the counter of its code in the same edge that registers the label. `cnt_value` shows the counter picked by `cnt_sel`, using the label encoding, without delay.
- R8: A counter that has reached 2^CNT_W-1 stays there and does not wrap.
- R9: `clr` zeroes all four counters and all loaded-once bits, and it takes priority over an increment or a fill in the same cycle. The touched bits are kept. An access presented in the same cycle is still labelled with the state from before the clear.
- R10: After a reset, `lbl_valid` is low, all counters read zero, and all touched and loaded-once bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_hit | input | 1 | Hit (1) or miss (0) reported by the cache |
| fill_valid | input | 1 | A line fill happens this cycle |
| fill_addr | input | ADDR_W | Word address that caused the fill |
| clr | input | 1 | Clear the counters and the loaded-once bits |
| cnt_sel | input | 2 | Selects the counter to read (label encoding) |
| lbl_valid | output | 1 | Label strobe, one cycle after the access |
| lbl_code | output | 2 | Label: 0 temporal, 1 spatial, 2 compulsory, 3 conflict |
| cnt_value | output | CNT_W | Value of the selected counter |

## Verification
The assertions check on every cycle that the strobe follows the access by one cycle, that hits and misses land in the correct half of the code space, that a fill leaves its line with a single touched bit and its block marked as loaded, and that the counters stick at their maximum and go to zero on a clear. The bench's scenarios are needed to show that the history itself is right. These cover a conflicting block that displaces a line and then comes back as a conflict miss, a spatial hit turning into a temporal hit on reuse, touched bits surviving a clear, the loaded-once history being forgotten after a clear, and same-cycle fill and access ordering under random traffic.

// File: rtl/coc_pkg.sv
// Package: shared label encoding for the access classifier.
// Assumes: the code order is visible at the ports and used by cnt_sel.
package coc_pkg;
    typedef enum logic [1:0] {
        CLS_TEMPORAL   = 2'd0,
        CLS_SPATIAL    = 2'd1,
        CLS_COMPULSORY = 2'd2,
        CLS_CONFLICT   = 2'd3
    } acc_class_e;

    localparam int NUM_CLASSES = 4;
endpackage

// File: rtl/coc_word_history.sv
// Module: per-line, per-word touched bits.
// Does: reports whether the accessed word was touched during the current
// residency of its line; a fill resets the line to only the filling word,
// and a hit then marks its own word.
// Assumes: fill and hit addresses are word addresses; the fill update is
// applied first and the hit update after it.
module coc_word_history #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_v,
    input  logic [ADDR_W-1:0] fill_a,
    input  logic              hit_v,
    input  logic [ADDR_W-1:0] acc_a,
    output logic              seen
);
    localparam int WORDS = 1 << OFF_W;
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0][WORDS-1:0] touched;
    logic [IDX_W-1:0] f_idx, a_idx;
    logic [OFF_W-1:0] f_off, a_off;

    assign f_idx = fill_a[OFF_W+IDX_W-1:OFF_W];
    assign f_off = fill_a[OFF_W-1:0];
    assign a_idx = acc_a[OFF_W+IDX_W-1:OFF_W];
    assign a_off = acc_a[OFF_W-1:0];

    // Look up the touched bit of the accessed word (state before this edge).
    assign seen = touched[a_idx][a_off];

    // Update the touched bits: the fill first, the hit after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            touched <= '0;
        end else begin
            if (fill_v) begin
                touched[f_idx]        <= '0;
                touched[f_idx][f_off] <= 1'b1;
            end
            if (hit_v) begin
                touched[a_idx][a_off] <= 1'b1;
            end
        end
    end

    // R5: a fill with no hit in the same cycle leaves exactly one touched bit in its line.
    a_r5_fill_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_v && !hit_v) |=> ($countones(touched[$past(f_idx)]) == 1));

    // R5: the word of a hit is marked touched on the next cycle.
    a_r5_hit_marks_word: assert property (@(posedge clk) disable iff (!rst_n)
        hit_v |=> touched[$past(a_idx)][$past(a_off)]);
endmodule

// File: rtl/coc_block_history.sv
// Module: loaded-once bit for each memory block of the address space.
// Does: marks a block when it is filled; a clear forgets every block.
// Assumes: the clear takes priority over a fill in the same cycle.
module coc_block_history #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fill_v,
    input  logic [ADDR_W-1:0] fill_a,
    input  logic [ADDR_W-1:0] acc_a,
    output logic              loaded
);
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int BLOCKS = 1 << BLK_W;

    logic [BLOCKS-1:0] ever;
    logic [BLK_W-1:0]  f_blk, a_blk;

    assign f_blk  = fill_a[ADDR_W-1:OFF_W];
    assign a_blk  = acc_a[ADDR_W-1:OFF_W];

    // Look up the loaded-once bit of the accessed block.
    assign loaded = ever[a_blk];

    // Record fills, or forget all blocks on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ever <= '0;
        end else if (fill_v) begin
            ever[f_blk] <= 1'b1;
        end
    end

    // R5: a block that is filled without a clear is marked loaded afterwards.
    a_r5_block_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_v && !clr) |=> ever[$past(f_blk)]);

    // R9: a clear forgets every block.
    a_r9_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ever == '0));
endmodule

// File: rtl/coc_sat_counter.sv
// Module: saturating event counter with a synchronous clear.
// Does: counts increments, sticks at the all-ones value, and zeroes on a clear.
// Assumes: the clear wins over an increment in the same cycle.
module coc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    // Count events without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && cnt != MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: a counter at its maximum stays there unless it is cleared.
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX && !clr) |=> (cnt == MAX));

    // R9: a clear gives zero on the next cycle.
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/cache_outcome_classifier.sv
// Module: top of the cache access outcome classifier.
// Does: labels each access as a temporal hit, spatial hit, compulsory miss
// or conflict miss from the word and block history; registers the label
// one cycle later and counts every label in a saturating counter.
// Assumes: acc_hit is the cache's own verdict; fills arrive as separate events.
module cache_outcome_classifier
    import coc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_hit,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              clr,
    input  logic [1:0]        cnt_sel,
    output logic              lbl_valid,
    output logic [1:0]        lbl_code,
    output logic [CNT_W-1:0]  cnt_value
);
    logic        word_seen;
    logic        blk_loaded;
    acc_class_e  cls;
    logic [NUM_CLASSES-1:0] bump;
    logic [NUM_CLASSES-1:0][CNT_W-1:0] counts;

    coc_word_history #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_words (
        .clk    (clk),
        .rst_n  (rst_n),
        .fill_v (fill_valid),
        .fill_a (fill_addr),
        .hit_v  (acc_valid && acc_hit),
        .acc_a  (acc_addr),
        .seen   (word_seen)
    );

    coc_block_history #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_blocks (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .fill_v (fill_valid),
        .fill_a (fill_addr),
        .acc_a  (acc_addr),
        .loaded (blk_loaded)
    );

    // Choose the label of the current access from the history lookups.
    always_comb begin
        if (acc_hit) cls = word_seen  ? CLS_TEMPORAL : CLS_SPATIAL;
        else         cls = blk_loaded ? CLS_CONFLICT : CLS_COMPULSORY;
    end

    // Register the label and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lbl_valid <= 1'b0;
            lbl_code  <= 2'd0;
        end else begin
            lbl_valid <= acc_valid;
            if (acc_valid) lbl_code <= cls;
        end
    end

    // One saturating counter per label code.
    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cnt
        assign bump[k] = acc_valid && (cls == acc_class_e'(k));
        coc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (bump[k]),
            .cnt   (counts[k])
        );
    end

    // Present the selected counter.
    assign cnt_value = counts[cnt_sel];

    // R6: the strobe follows an access by exactly one cycle.
    a_r6_label_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> lbl_valid);
    a_r6_no_spurious_label: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !lbl_valid);

    // R1, R2: a hit is labelled in the hit half of the code space.
    a_r1_hit_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |=> (lbl_code[1] == 1'b0));

    // R3, R4: a miss is labelled in the miss half of the code space.
    a_r3_miss_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |=> (lbl_code[1] == 1'b1));

    // R7: at most one counter is bumped per access.
    a_r7_single_bump: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bump));
endmodule

// File: tb/sim_cache_outcome_classifier.sv
module sim_cache_outcome_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = 2;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic acc_valid = 0, acc_hit = 0, fill_valid = 0, clr = 0;
    logic [ADDR_W-1:0] acc_addr = '0, fill_addr = '0;
    logic [1:0] cnt_sel = '0;
    logic lbl_valid;
    logic [1:0] lbl_code;
    logic [CNT_W-1:0] cnt_value;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state
    bit m_touch [4][4];
    bit m_ever [64];
    int m_cnt [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_outcome_classifier #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_hit(acc_hit), .fill_valid(fill_valid), .fill_addr(fill_addr), .clr(clr),
        .cnt_sel(cnt_sel), .lbl_valid(lbl_valid), .lbl_code(lbl_code), .cnt_value(cnt_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        foreach (m_touch[i, j]) m_touch[i][j] = 0;
        foreach (m_ever[i]) m_ever[i] = 0;
        foreach (m_cnt[i]) m_cnt[i] = 0;
    endtask

    // One clock: drive at negedge, update the model, compare at the next negedge.
    task automatic step(input bit av, input int aa, input bit ah,
                        input bit fv, input int fa, input bit c, input string req);
        int exp_code = 0;
        int ln, wd, bl;
        acc_valid = av; acc_addr = aa[ADDR_W-1:0]; acc_hit = ah;
        fill_valid = fv; fill_addr = fa[ADDR_W-1:0]; clr = c;
        ln = (aa >> 2) & 3; wd = aa & 3; bl = (aa >> 2) & 63;
        if (av) begin
            if (ah) exp_code = m_touch[ln][wd] ? 0 : 1;
            else    exp_code = m_ever[bl] ? 3 : 2;
        end
        if (fv) begin
            for (int w = 0; w < 4; w++) m_touch[(fa >> 2) & 3][w] = 0;
            m_touch[(fa >> 2) & 3][fa & 3] = 1;
            m_ever[(fa >> 2) & 63] = 1;
        end
        if (av && ah) m_touch[ln][wd] = 1;
        if (c) begin
            foreach (m_ever[i]) m_ever[i] = 0;
            foreach (m_cnt[i]) m_cnt[i] = 0;
        end else if (av && m_cnt[exp_code] < CMAX) begin
            m_cnt[exp_code]++;
        end
        @(posedge clk);
        @(negedge clk);
        acc_valid = 0; fill_valid = 0; clr = 0;
        check({req, " R6 strobe"}, lbl_valid, av);
        if (av) check(req, lbl_code, exp_code);
    endtask

    task automatic check_counts(input string req);
        for (int k = 0; k < 4; k++) begin
            cnt_sel = k[1:0];
            #1;
            check({req, " R7 count"}, cnt_value, m_cnt[k]);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        check("R10 strobe", lbl_valid, 0);
        check_counts("R10");

        // Directed: compulsory, temporal, spatial
        step(1, 8'h00, 0, 0, 0, 0, "R3 first miss");
        step(0, 0, 0, 1, 8'h00, 0, "R5 fill");
        step(1, 8'h00, 1, 0, 0, 0, "R1 filling word");
        step(1, 8'h01, 1, 0, 0, 0, "R2 neighbour");
        step(1, 8'h01, 1, 0, 0, 0, "R1 reuse");
        // Conflicting block displaces line 0, then comes back
        step(1, 8'h10, 0, 1, 8'h10, 0, "R3 conflicting block");
        step(1, 8'h11, 1, 0, 0, 0, "R2 after refill");
        step(1, 8'h00, 0, 0, 0, 0, "R4 returning block");
        step(0, 0, 0, 1, 8'h02, 0, "R5 refill by word 2");
        step(1, 8'h02, 1, 0, 0, 0, "R1 word 2");
        step(1, 8'h00, 1, 0, 0, 0, "R5 cleared on fill");
        step(0, 0, 0, 0, 0, 0, "R6 idle");
        check_counts("R7 directed");

        // Clear: loaded-once forgotten, touched bits kept, access same cycle uses old state
        step(1, 8'h10, 0, 0, 0, 1, "R9 access with clear");
        check_counts("R9 after clear");
        step(1, 8'h00, 0, 0, 0, 0, "R9 forgotten block");
        step(1, 8'h02, 1, 0, 0, 0, "R9 touched kept");
        step(1, 8'h01, 1, 1, 8'h01, 0, "R5 same-cycle fill and hit");
        step(1, 8'h01, 1, 0, 0, 0, "R5 same-cycle result");

        // Saturation
        for (int i = 0; i < CMAX + 5; i++) step(1, 8'h02, 1, 0, 0, 0, "R8 repeat");
        check_counts("R8 saturated");
        step(1, 8'h02, 1, 0, 0, 1, "R9 clear beats increment");
        check_counts("R9 priority");

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 255), $urandom_range(0, 1),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 255), $urandom_range(0, 60) == 0,
                 "R1 R2 R3 R4 random");
            if (i % 50 == 49) check_counts("R7 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule